// File: doc/BRIEF.md
# Skewed-Sample Majority Register

This block is a pipeline register that removes short single-event transients from its data input. It does not latch the input once. It takes three samples of the same input word at instants spaced a programmable number of fast-clock ticks apart, and it registers the bitwise two-of-three vote of those samples. A transient that is narrower than the spacing can reach at most one sample, so the vote discards it. The vote result is held in a register, so a glitch that forms inside the voting gates is cleaned up by the next stage of the same kind.

The block runs on one fast oversampling clock. A base strobe marks each logical sample point. The spacing, in ticks, is held in a small configuration register. Software can raise the spacing to tolerate wider transients, as long as the whole triple still fits inside the base strobe period. A write that does not fit is refused, and it sets a sticky error flag. A debug mask shows which bits disagreed across the three samples in the most recent vote.

A sequencer controls the capture. It has four states:
- IDLE: no triple is in progress.
- FIRST_GAP: waiting for the second sample.
- SECOND_GAP: waiting for the third sample.
- VOTE: the voted word is registered.

The transitions are:
- IDLE→FIRST_GAP and VOTE→FIRST_GAP on an accepted strobe.
- FIRST_GAP→SECOND_GAP when the gap counter reaches the spacing.
- SECOND_GAP→VOTE when the gap counter reaches the spacing.
- VOTE→IDLE when no strobe is present.

Top module: `skew_vote_reg`

## Requirements
- R1: After reset, `dout`, `dout_valid`, `dbg_mismatch` and `cfg_err` are all zero. The active spacing is the parameter `DT_INIT` (default 2).
- R2: Let a strobe be sampled high at clock edge N, with active spacing D. The block samples `din` at edges N, N+D and N+2D. It registers the bitwise majority of those three words into `dout`.
- R3: If only one of the three samples differs from the other two, in any bit positions, `dout` equals the value shared by the other two samples.
- R4: `dout_valid` is high for exactly one cycle, after edge N+2D+1. `dout` takes its new value at that same edge.
- R5: A configuration write of 0 or 1 gives a spacing of 1 tick, so a triple completes with `dout_valid` after edge N+3.
- R6: A write is accepted only if 2·max(value,1)+1 ≤ `BASE_PERIOD` (default 16). Otherwise the write is discarded, the previous spacing stays in force, and `cfg_err` goes high and stays high until reset.
- R7: An accepted write is applied from the next strobe onward. A triple already in progress keeps the spacing it started with.
- R8: A strobe that arrives while the block is in FIRST_GAP or SECOND_GAP is ignored. It produces no extra result and does not disturb the current triple. A strobe in IDLE or VOTE starts a new triple.
- R9: `dout` does not change in any cycle in which `dout_valid` is low.
- R10: `dbg_mismatch` bit i is set when the three samples of bit i were not all equal in the last vote. It changes only together with `dout_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | WIDTH | Data word to be sampled |
| strobe | input | 1 | Base sample point; starts a triple when accepted |
| cfg_we | input | 1 | Write enable for the spacing register |
| cfg_dt | input | DT_W | Requested spacing in fast-clock ticks |
| dout | output | WIDTH | Registered majority of the three samples |
| dout_valid | output | 1 | One-cycle pulse when `dout` has been updated |
| dbg_mismatch | output | WIDTH | Per-bit disagreement mask of the last vote |
| cfg_err | output | 1 | Sticky flag for a rejected spacing write |

## Verification
The hardest behaviour to exercise from the ports is the exact choice of sample instants. With a constant input, the block would give the same result whatever ticks it sampled. The driver therefore changes `din` on every tick of a triple. It places the intended words only at offsets 0, D and 2D and puts a conflicting junk word in every other tick, so sampling one tick early or late changes the vote. A spacing write issued in the middle of a triple, and a second strobe issued during a gap, check that the spacing in use and the triple in progress are kept until the next accepted strobe.

// File: rtl/skv_pkg.sv
package skv_pkg;

    localparam int SKV_DT_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_FIRST_GAP  = 2'd1,
        ST_SECOND_GAP = 2'd2,
        ST_VOTE       = 2'd3
    } skv_state_e;

    localparam int SKV_COPIES = 3;

endpackage

// File: rtl/skv_cfg.sv
module skv_cfg #(
    parameter int DT_W        = 4,
    parameter int BASE_PERIOD = 16,
    parameter int DT_INIT     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [DT_W-1:0] cfg_dt,
    output logic [DT_W-1:0] dt_pend,
    output logic            cfg_err
);

    localparam logic [DT_W-1:0] ONE = DT_W'(1);

    logic [DT_W-1:0] eff_dt;
    logic            fits;

    always_comb begin
        eff_dt = (cfg_dt > ONE) ? cfg_dt : ONE;
        fits   = (int'({eff_dt, 1'b1}) <= BASE_PERIOD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dt_pend <= DT_W'(DT_INIT);
            cfg_err <= 1'b0;
        end else if (cfg_we) begin
            if (fits) begin
                dt_pend <= eff_dt;
            end else begin
                cfg_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/skv_seq.sv
module skv_seq
    import skv_pkg::*;
#(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe,
    input  logic [DT_W-1:0] dt_pend,
    output logic            start,
    output logic [2:0]      cap_en,
    output logic            vote_en,
    output logic [DT_W-1:0] dt_run
);

    localparam logic [DT_W-1:0] ONE = DT_W'(1);

    skv_state_e      state_q, state_d;
    logic [DT_W-1:0] cnt_q;
    logic            gap_hit;

    // state, gap counter and latched spacing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= ONE;
            dt_run  <= ONE;
        end else begin
            state_q <= state_d;
            if (start) begin
                cnt_q  <= ONE;
                dt_run <= dt_pend;
            end else if (state_q == ST_FIRST_GAP || state_q == ST_SECOND_GAP) begin
                cnt_q <= gap_hit ? ONE : cnt_q + ONE;
            end
        end
    end

    // next state and decoded outputs
    always_comb begin
        gap_hit = (cnt_q == dt_run);
        start   = 1'b0;
        cap_en  = 3'b000;
        vote_en = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                start = strobe;
                if (strobe) state_d = ST_FIRST_GAP;
            end
            ST_FIRST_GAP: begin
                if (gap_hit) begin
                    cap_en[1] = 1'b1;
                    state_d   = ST_SECOND_GAP;
                end
            end
            ST_SECOND_GAP: begin
                if (gap_hit) begin
                    cap_en[2] = 1'b1;
                    state_d   = ST_VOTE;
                end
            end
            ST_VOTE: begin
                vote_en = 1'b1;
                start   = strobe;
                state_d = strobe ? ST_FIRST_GAP : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        cap_en[0] = start;
    end

endmodule

// File: rtl/skv_capture.sv
module skv_capture
    import skv_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [WIDTH-1:0]                  din,
    input  logic [SKV_COPIES-1:0]             cap_en,
    output logic [SKV_COPIES-1:0][WIDTH-1:0]  samples
);

    for (genvar c = 0; c < SKV_COPIES; c++) begin : g_copy
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                samples[c] <= '0;
            end else if (cap_en[c]) begin
                samples[c] <= din;
            end
        end
    end

endmodule

// File: rtl/skv_vote.sv
module skv_vote
    import skv_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              vote_en,
    input  logic [SKV_COPIES-1:0][WIDTH-1:0]  samples,
    output logic [WIDTH-1:0]                  dout,
    output logic [WIDTH-1:0]                  dbg_mismatch,
    output logic                              dout_valid
);

    logic [WIDTH-1:0] maj;
    logic [WIDTH-1:0] disagree;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_comb begin
            maj[b] = (samples[0][b] & samples[1][b])
                   | (samples[0][b] & samples[2][b])
                   | (samples[1][b] & samples[2][b]);
            disagree[b] = (samples[0][b] != samples[1][b])
                        | (samples[1][b] != samples[2][b]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout         <= '0;
            dbg_mismatch <= '0;
            dout_valid   <= 1'b0;
        end else begin
            dout_valid <= vote_en;
            if (vote_en) begin
                dout         <= maj;
                dbg_mismatch <= disagree;
            end
        end
    end

endmodule

// File: rtl/skew_vote_reg.sv
module skew_vote_reg
    import skv_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int DT_W        = SKV_DT_W,
    parameter int BASE_PERIOD = 16,
    parameter int DT_INIT     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic             strobe,
    input  logic             cfg_we,
    input  logic [DT_W-1:0]  cfg_dt,
    output logic [WIDTH-1:0] dout,
    output logic             dout_valid,
    output logic [WIDTH-1:0] dbg_mismatch,
    output logic             cfg_err
);

    logic [DT_W-1:0]                  dt_pend;
    logic [DT_W-1:0]                  dt_run;
    logic                             start;
    logic [SKV_COPIES-1:0]            cap_en;
    logic                             vote_en;
    logic [SKV_COPIES-1:0][WIDTH-1:0] samples;

    skv_cfg #(
        .DT_W       (DT_W),
        .BASE_PERIOD(BASE_PERIOD),
        .DT_INIT    (DT_INIT)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_we (cfg_we),
        .cfg_dt (cfg_dt),
        .dt_pend(dt_pend),
        .cfg_err(cfg_err)
    );

    skv_seq #(.DT_W(DT_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .dt_pend(dt_pend),
        .start  (start),
        .cap_en (cap_en),
        .vote_en(vote_en),
        .dt_run (dt_run)
    );

    skv_capture #(.WIDTH(WIDTH)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (din),
        .cap_en (cap_en),
        .samples(samples)
    );

    skv_vote #(.WIDTH(WIDTH)) u_vote (
        .clk         (clk),
        .rst_n       (rst_n),
        .vote_en     (vote_en),
        .samples     (samples),
        .dout        (dout),
        .dbg_mismatch(dbg_mismatch),
        .dout_valid  (dout_valid)
    );

endmodule

// File: rtl/skv_chk.sv
module skv_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cap_en,
    input logic [WIDTH-1:0] dout,
    input logic             dout_valid,
    input logic [WIDTH-1:0] dbg_mismatch,
    input logic             cfg_err
);

    // R2
    cap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cap_en));

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |=> !dout_valid);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R9
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_valid |-> $stable(dout));

    // R10
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_valid |-> $stable(dbg_mismatch));

endmodule

bind skew_vote_reg skv_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_en      (cap_en),
    .dout        (dout),
    .dout_valid  (dout_valid),
    .dbg_mismatch(dbg_mismatch),
    .cfg_err     (cfg_err)
);

// File: tb/tb_skew_vote_reg.sv
`timescale 1ns/1ps
module tb_skew_vote_reg;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] din = '0;
    logic         strobe = 1'b0;
    logic         cfg_we = 1'b0;
    logic [3:0]   cfg_dt = '0;
    logic [W-1:0] dout;
    logic         dout_valid;
    logic [W-1:0] dbg_mismatch;
    logic         cfg_err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [W-1:0] d;
        logic [W-1:0] m;
        int           lat;
        int           at;
        string        tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    skew_vote_reg dut (
        .clk(clk), .rst_n(rst_n), .din(din), .strobe(strobe),
        .cfg_we(cfg_we), .cfg_dt(cfg_dt), .dout(dout),
        .dout_valid(dout_valid), .dbg_mismatch(dbg_mismatch), .cfg_err(cfg_err)
    );

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(logic [3:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_dt = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // one triple; junk word on every tick that is not a sample instant
    task automatic drive_triple(int dt, logic [W-1:0] v0, v1, v2,
                                bit mid_cfg, logic [3:0] mid_val,
                                bit extra_strobe, int gap, string tag);
        exp_t e;
        @(negedge clk);
        strobe = 1'b1; din = v0;
        e.d   = (v0 & v1) | (v0 & v2) | (v1 & v2);
        e.m   = (v0 ^ v1) | (v1 ^ v2);
        e.lat = 2 * dt + 1;
        e.at  = cyc + 1;
        e.tag = tag;
        sb.push_back(e);
        for (int k = 1; k <= 2 * dt; k++) begin
            @(negedge clk);
            strobe = (extra_strobe && k == 2);
            cfg_we = (mid_cfg && k == 1);
            cfg_dt = mid_val;
            din = (k == dt) ? v1 : (k == 2 * dt) ? v2 : ~(e.d);
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            strobe = 1'b0; cfg_we = 1'b0; din = ~(e.d);
        end
    endtask

    // monitor / scoreboard
    logic [W-1:0] prev_dout = '0;
    bit           prev_valid = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (dout_valid) begin
                if (prev_valid) check(1'b0, "R4 double valid", 1, 0);
                if (sb.size() == 0) begin
                    check(1'b0, "R8 unexpected result", dout, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(dout == e.d, {e.tag, " dout"}, dout, e.d);
                    check(dbg_mismatch == e.m, {e.tag, " R10 mask"}, dbg_mismatch, e.m);
                    check(cyc - e.at == e.lat, {e.tag, " R4 latency"}, cyc - e.at, e.lat);
                end
            end else begin
                check(dout == prev_dout, "R9 hold", dout, prev_dout);
            end
            prev_dout  = dout;
            prev_valid = dout_valid;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(dout == 0 && dout_valid == 0 && dbg_mismatch == 0 && cfg_err == 0,
              "R1 reset", {dout, dbg_mismatch, 7'd0, dout_valid, 7'd0, cfg_err}, 0);
        rst_n = 1'b1;
        // R2 default spacing
        drive_triple(2, 8'h3C, 8'h3C, 8'h3C, 0, 0, 0, 2, "R2");
        write_cfg(4'd3);
        check(cfg_err == 0, "R6 valid write", cfg_err, 0);
        // R3 single corrupted sample at each position
        drive_triple(3, 8'h5A, 8'hFF, 8'h5A, 0, 0, 0, 1, "R3");
        drive_triple(3, 8'h00, 8'hC3, 8'hC3, 0, 0, 0, 0, "R3");
        drive_triple(3, 8'h81, 8'h81, 8'h7E, 0, 0, 0, 3, "R2 back-to-back R3");
        // R5 clamp
        write_cfg(4'd0);
        drive_triple(1, 8'h11, 8'h11, 8'h22, 0, 0, 0, 2, "R5");
        write_cfg(4'd1);
        drive_triple(1, 8'hF0, 8'h0F, 8'hF0, 0, 0, 0, 2, "R5");
        // largest fitting spacing
        write_cfg(4'd7);
        check(cfg_err == 0, "R6 limit accepted", cfg_err, 0);
        drive_triple(7, 8'hA5, 8'hA5, 8'h5A, 0, 0, 0, 1, "R6 limit");
        // R6 rejected write
        write_cfg(4'd8);
        check(cfg_err == 1, "R6 error set", cfg_err, 1);
        drive_triple(7, 8'h66, 8'h99, 8'h66, 0, 0, 0, 1, "R6 ignored");
        write_cfg(4'd2);
        check(cfg_err == 1, "R6 sticky", cfg_err, 1);
        // R7 write mid-triple
        drive_triple(2, 8'h12, 8'h12, 8'h12, 1, 4'd5, 0, 2, "R7 old");
        drive_triple(5, 8'h34, 8'h35, 8'h34, 0, 0, 0, 2, "R7 new");
        // R8 strobe during a gap
        drive_triple(5, 8'hC0, 8'hC0, 8'h03, 0, 0, 1, 4, "R8");
        // R10 all three differ
        drive_triple(5, 8'h0F, 8'h33, 8'h55, 0, 0, 0, 4, "R10");
        repeat (20) @(negedge clk);
        check(sb.size() == 0, "R4 results outstanding", sb.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule